// File: doc/BRIEF.md
# Operand Bit Mismatch Counter

A small register-mapped peripheral that holds two 8-bit operands, X and Y. A CPU writes them over a simple synchronous register bus. The block keeps a count of the bit positions where X and Y differ, and exposes it in the low nibble of a read-only status register. Any write to either operand triggers a recount. No start command is needed.

A common use is counting ones or zeros in a byte. Load X with 00h and the status gives the number of ones in Y. Load X with FFh and it gives the number of zeros in Y.

The bus has a word address, a write strobe and write data. A combinational read data path returns the register at the current address. The status register loads at the same clock edge that stores the operand, so the new count can be read from the next cycle on.

Top module: `hd_mismatch_counter`

## Requirements
- R1: After reset, X (address 0), Y (address 1) and status (address 2) all read 00h.
- R2: A write with address 0 stores the data in X, and a write with address 1 stores it in Y; each reads back unchanged.
- R3: Status bits 3:0 hold the number of bit positions in which X and Y differ, a value from 0 to 8.
- R4: Status bits 7:4 always read as zero.
- R5: After a write to either operand, the updated count is readable in the next cycle.
- R6: With X equal to 00h, the count equals the number of ones in Y.
- R7: With X equal to FFh, the count equals the number of zeros in Y.
- R8: Rewriting an operand with its current value recomputes and yields the same count.
- R9: Writes to address 2 (status) or address 3 (unmapped) leave X, Y and status unchanged.
- R10: Reads have no side effects, and address 3 reads as 00h.
- R11: While no operand is written, the status value stays stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register word address (0 = X, 1 = Y, 2 = status, 3 = unmapped) |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |

## Verification
The assertions assume that the address, write strobe and write data settle well before each rising edge. They also assume that a write lasts exactly one cycle per bus transfer. The bench meets this by changing inputs only on the falling edge, and by dropping the strobe after one edge. The bench waits out the internal reset release before its first access, so no write is lost while the block is still held in reset. The count checks sample read data half a cycle after the write edge. That is the earliest point the requirements promise.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int unsigned OPND_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned CNT_W   = $clog2(OPND_W + 1);

  typedef enum logic [ADDR_W-1:0] {
    REG_OPND_X = 2'd0,
    REG_OPND_Y = 2'd1,
    REG_STAT   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/hd_reset_sync.sv
module hd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hd_operand_regs.sv
module hd_operand_regs
  import hd_pkg::*;
#(
  parameter int unsigned W  = OPND_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  x_q,
  output logic [W-1:0]  y_q,
  output logic [W-1:0]  x_nxt,
  output logic [W-1:0]  y_nxt,
  output logic          recompute
);
  logic x_en, y_en;

  always_comb begin
    x_en  = wr && (addr == AW'(REG_OPND_X));
    y_en  = wr && (addr == AW'(REG_OPND_Y));
    x_nxt = x_en ? wdata : x_q;
    y_nxt = y_en ? wdata : y_q;
    recompute = x_en || y_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    x_q <= '0;
    else if (x_en) x_q <= x_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    y_q <= '0;
    else if (y_en) y_q <= y_nxt;
  end

  // R9: a write to any other address must leave both operands untouched
  p_no_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != AW'(REG_OPND_X) && addr != AW'(REG_OPND_Y)) |=> ($stable(x_q) && $stable(y_q)));
endmodule

// File: rtl/hd_popcount.sv
module hd_popcount #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] diff;

  assign diff = a ^ b;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(diff[i]);
    end
  end
endmodule

// File: rtl/hd_status_reg.sv
module hd_status_reg #(
  parameter int unsigned CW = 4,
  parameter int unsigned W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cnt_in,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = cnt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= cnt_d;
  end

  // R11: without an operand write, the held count must not move
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cnt_q));
  // R3: the count can never exceed the operand width
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W));
endmodule

// File: rtl/hd_read_mux.sv
module hd_read_mux
  import hd_pkg::*;
#(
  parameter int unsigned W  = OPND_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  x_q,
  input  logic [W-1:0]  y_q,
  input  logic [CW-1:0] cnt_q,
  output logic [W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      AW'(REG_OPND_X): rdata = x_q;
      AW'(REG_OPND_Y): rdata = y_q;
      AW'(REG_STAT):   rdata = W'(cnt_q);
      default:         rdata = '0;
    endcase
  end

  // R4: upper status bits read as zero
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(REG_STAT)) |-> (rdata[W-1:CW] == '0));
  // R10: the unmapped address reads as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(REG_NONE)) |-> (rdata == '0));
endmodule

// File: rtl/hd_mismatch_counter.sv
module hd_mismatch_counter
  import hd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [OPND_W-1:0] bus_wdata,
  output logic [OPND_W-1:0] bus_rdata
);
  logic              rst_n_s;
  logic [OPND_W-1:0] x_q, y_q, x_nxt, y_nxt;
  logic              recompute;
  logic [CNT_W-1:0]  cnt_next, cnt_q;

  hd_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  hd_operand_regs #(.W(OPND_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .x_q(x_q), .y_q(y_q), .x_nxt(x_nxt), .y_nxt(y_nxt), .recompute(recompute)
  );

  hd_popcount #(.W(OPND_W), .CW(CNT_W)) u_pop (
    .a(x_nxt), .b(y_nxt), .cnt(cnt_next)
  );

  hd_status_reg #(.CW(CNT_W), .W(OPND_W)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .load(recompute), .cnt_in(cnt_next), .cnt_q(cnt_q)
  );

  hd_read_mux #(.W(OPND_W), .AW(ADDR_W), .CW(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n_s), .addr(bus_addr), .x_q(x_q), .y_q(y_q),
    .cnt_q(cnt_q), .rdata(bus_rdata)
  );

  // R5: one edge after an operand write, the status matches the stored operands
  p_fresh_count_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    recompute |=> (int'(cnt_q) == $countones(x_q ^ y_q)));
  // R3: identical operands always give a zero count
  p_equal_zero_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (x_q == y_q) |-> (cnt_q == '0));
endmodule

// File: tb/hd_mismatch_counter_tb_top.sv
module hd_mismatch_counter_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] mx = 8'd0, my = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hd_mismatch_counter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic int ones8(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a == 2'd0) mx = d;
    if (a == 2'd1) my = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_stat();
    return 8'(ones8(mx ^ my));
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    bus_read(2'd0, v); check("R1 X", v, 8'h00);
    bus_read(2'd1, v); check("R1 Y", v, 8'h00);
    bus_read(2'd2, v); check("R1 status", v, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    bus_write(2'd0, 8'h5A); bus_read(2'd0, v); check("R2 X", v, 8'h5A);
    bus_read(2'd2, v); check("R5 after X write", v, exp_stat());
    bus_write(2'd1, 8'hC3); bus_read(2'd1, v); check("R2 Y", v, 8'hC3);
    bus_read(2'd2, v); check("R5 after Y write", v, exp_stat());
  endtask

  task automatic t_extremes;
    logic [7:0] v;
    bus_write(2'd0, 8'h00); bus_write(2'd1, 8'hFF);
    bus_read(2'd2, v); check("R3 all differ", v, 8'h08);
    check("R4 upper zero", v & 8'hF0, 8'h00);
    bus_write(2'd0, 8'hFF);
    bus_read(2'd2, v); check("R3 all equal", v, 8'h00);
  endtask

  task automatic t_ones_zeros;
    logic [7:0] v;
    logic [7:0] pats [4] = '{8'hA5, 8'h01, 8'h7E, 8'h80};
    bus_write(2'd0, 8'h00);
    foreach (pats[k]) begin
      bus_write(2'd1, pats[k]); bus_read(2'd2, v);
      check("R6 ones of Y", v, 8'(ones8(pats[k])));
    end
    bus_write(2'd0, 8'hFF);
    foreach (pats[k]) begin
      bus_write(2'd1, pats[k]); bus_read(2'd2, v);
      check("R7 zeros of Y", v, 8'(8 - ones8(pats[k])));
    end
  endtask

  task automatic t_rewrite;
    logic [7:0] v;
    bus_write(2'd0, 8'h3C); bus_write(2'd1, 8'h0F);
    bus_write(2'd1, 8'h0F); bus_read(2'd2, v); check("R8 rewrite Y", v, 8'h04);
    bus_write(2'd0, 8'h3C); bus_read(2'd2, v); check("R8 rewrite X", v, 8'h04);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    bus_write(2'd2, 8'hFF); bus_write(2'd3, 8'hAA);
    bus_read(2'd0, v); check("R9 X kept", v, mx);
    bus_read(2'd1, v); check("R9 Y kept", v, my);
    bus_read(2'd2, v); check("R9 status kept", v, exp_stat());
  endtask

  task automatic t_reads;
    logic [7:0] v;
    bus_read(2'd3, v); check("R10 unmapped", v, 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); bus_read(2'd2, v);
    end
    check("R10 repeated read", v, exp_stat());
    repeat (5) @(negedge clk);
    bus_read(2'd2, v); check("R11 idle hold", v, exp_stat());
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_extremes();
    t_ones_zeros();
    t_rewrite();
    t_ignored();
    t_reads();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule